// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block walks a linked list of DMA descriptors that sits in host memory. Software starts a walk by writing the physical address of the first descriptor to the pointer input. The walker then fetches that descriptor as three 32-bit words over a read interface. Each read is a request/response pair, and only one read is in flight at a time.

Each descriptor gives a buffer address, a byte length and a link word. The link word holds the address of the next descriptor. Its two low bits are flags: one marks the end of the chain, and the other gives the transfer direction. The walker passes each segment (address, length, direction) to a downstream data mover over a valid/ready handshake. It then waits for the mover to report that the segment is done. After that it follows the link, with the flag bits cleared, to the next descriptor. When the final segment finishes, the walker raises a sticky chain-done bit and goes back to idle.

The data movement itself, and the host bus protocol behind the read interface, are outside this block.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `busy`, `chain_done`, `rd_req_valid` and `seg_valid` are all 0.
- R2: A `ptr_wr` pulse while idle starts a walk. On the next cycle `busy` is 1 and `rd_req_valid` is 1, with `rd_req_addr` equal to the written pointer.
- R3: A descriptor is read as three words, in order, at pointer, pointer+4 and pointer+8. After a request is accepted, no new request is raised until the response to it has arrived.
- R4: The segment offered downstream carries word 0 as `seg_addr` and word 1 as `seg_len`.
- R5: `seg_to_host` equals bit 1 of word 2. A value of 1 means board to host memory, and 0 means host memory to board.
- R6: If bit 0 of word 2 is 0, no read is issued while the segment is in progress. Once `seg_done` is seen, the next descriptor is fetched from word 2 with bits 1:0 forced to 0.
- R7: If bit 0 of word 2 is 1, then after `seg_done` the signal `chain_done` becomes 1 and `busy` becomes 0, and no further read is issued.
- R8: While `rd_req_valid` is high and not accepted, it stays high and `rd_req_addr` does not change. While `seg_valid` is high and not accepted, it stays high and the segment fields do not change.
- R9: A `ptr_wr` pulse while `busy` is 1 has no effect. The walk goes on through the addresses given by the chain.
- R10: `chain_done` stays 1 while idle and clears on the cycle after the next accepted pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_wr | input | 1 | Write strobe for the first-descriptor pointer |
| ptr_value | input | 32 | Physical address of the first descriptor |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data word |
| seg_valid | output | 1 | Segment offer valid |
| seg_ready | input | 1 | Segment accepted by the data mover |
| seg_addr | output | 32 | Segment buffer address |
| seg_len | output | 32 | Segment length |
| seg_to_host | output | 1 | 1 = board to host memory, 0 = host memory to board |
| seg_done | input | 1 | Pulse: the accepted segment has been moved |
| busy | output | 1 | A chain walk is in progress |
| chain_done | output | 1 | Sticky: the last segment of the chain has completed |

## Verification
The walker is exercised with two directed chains, a single descriptor and a three-descriptor chain with mixed directions, and then with random chains of one to five descriptors. The random chains use random buffer addresses, lengths, directions and link locations.

The memory side and the data-mover side each stall for a random number of cycles. Stalls on the read request separate correct request holding from early withdrawal. Response latency separates single-outstanding sequencing from reads that overlap. Stalls on the segment handshake, and gaps before `seg_done`, show whether the walker holds the segment and waits for completion or runs ahead.

Link words carry set flag bits on purpose, so an unmasked next address shows up as a wrong read address. Pointer writes injected mid-walk confirm that an active chain cannot be redirected.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int WORD_W      = 32;
    localparam int DESC_WORDS  = 3;
    localparam int WORD_BYTES  = WORD_W / 8;
    localparam int IDX_W       = $clog2(DESC_WORDS);
    localparam int FLAG_END    = 0;
    localparam int FLAG_TOHOST = 1;
    localparam int FLAG_BITS   = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t addr;
        word_t len;
        logic  to_host;
    } seg_t;

    typedef struct packed {
        seg_t  seg;
        word_t link;
        logic  is_end;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OFFER,
        ST_AWAIT
    } walk_st_e;

    function automatic word_t strip_flags(word_t w);
        word_t m;
        m = w;
        m[FLAG_BITS-1:0] = '0;
        return m;
    endfunction

    function automatic desc_t build_desc(word_t w_addr, word_t w_len, word_t w_link);
        desc_t d;
        d.seg.addr    = w_addr;
        d.seg.len     = w_len;
        d.seg.to_host = w_link[FLAG_TOHOST];
        d.link        = strip_flags(w_link);
        d.is_end      = w_link[FLAG_END];
        return d;
    endfunction

endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch
    import sgw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t start_addr,
    output logic  req_valid,
    input  logic  req_ready,
    output word_t req_addr,
    input  logic  rsp_valid,
    input  word_t rsp_data,
    output logic  desc_valid,
    output desc_t desc
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic [IDX_W-1:0] idx;
    logic             waiting;
    word_t            base_q;
    word_t            hold [DESC_WORDS];

    assign req_addr = base_q + word_t'(idx) * word_t'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid  <= 1'b0;
            waiting    <= 1'b0;
            idx        <= '0;
            desc_valid <= 1'b0;
            base_q     <= '0;
            desc       <= '0;
            for (int i = 0; i < DESC_WORDS; i++) hold[i] <= '0;
        end else begin
            desc_valid <= 1'b0;
            if (start) begin
                base_q    <= start_addr;
                idx       <= '0;
                req_valid <= 1'b1;
                waiting   <= 1'b0;
            end else if (req_valid && req_ready) begin
                req_valid <= 1'b0;
                waiting   <= 1'b1;
            end else if (waiting && rsp_valid) begin
                waiting <= 1'b0;
                if (idx == LAST_IDX) begin
                    desc       <= build_desc(hold[0], hold[1], rsp_data);
                    desc_valid <= 1'b1;
                end else begin
                    hold[idx] <= rsp_data;
                    idx       <= idx + 1'b1;
                    req_valid <= 1'b1;
                end
            end
        end
    end

    // R8: a stalled request keeps its address
    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    // R3: a request raised after a response steps by one word
    p_word_step_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) && !$past(start) |-> req_addr == $past(req_addr) + word_t'(WORD_BYTES));

    // R3: no request while one is in flight
    p_single_flight_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !start |=> !req_valid);

endmodule

// File: rtl/sgw_seg_port.sv
module sgw_seg_port
    import sgw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  seg_t seg_in,
    output logic valid,
    input  logic ready,
    output seg_t seg_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            seg_out <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            seg_out <= seg_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R8: a stalled segment offer keeps its fields
    p_seg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(seg_out));

endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
    import sgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ptr_wr,
    input  logic [31:0] ptr_value,
    output logic        rd_req_valid,
    input  logic        rd_req_ready,
    output logic [31:0] rd_req_addr,
    input  logic        rd_rsp_valid,
    input  logic [31:0] rd_rsp_data,
    output logic        seg_valid,
    input  logic        seg_ready,
    output logic [31:0] seg_addr,
    output logic [31:0] seg_len,
    output logic        seg_to_host,
    input  logic        seg_done,
    output logic        busy,
    output logic        chain_done
);

    walk_st_e st;
    word_t    link_q;
    logic     end_q;
    logic     fetch_start;
    word_t    fetch_base;
    logic     desc_valid;
    desc_t    desc;
    seg_t     seg_q;

    assign fetch_start = (st == ST_IDLE && ptr_wr) ||
                         (st == ST_AWAIT && seg_done && !end_q);
    assign fetch_base  = (st == ST_IDLE) ? ptr_value : link_q;
    assign busy        = (st != ST_IDLE);

    sgw_desc_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (fetch_start),
        .start_addr (fetch_base),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_addr   (rd_req_addr),
        .rsp_valid  (rd_rsp_valid),
        .rsp_data   (rd_rsp_data),
        .desc_valid (desc_valid),
        .desc       (desc)
    );

    sgw_seg_port u_seg (
        .clk     (clk),
        .rst     (rst),
        .load    (desc_valid),
        .seg_in  (desc.seg),
        .valid   (seg_valid),
        .ready   (seg_ready),
        .seg_out (seg_q)
    );

    assign seg_addr    = seg_q.addr;
    assign seg_len     = seg_q.len;
    assign seg_to_host = seg_q.to_host;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            chain_done <= 1'b0;
            link_q     <= '0;
            end_q      <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (ptr_wr) begin
                    st         <= ST_FETCH;
                    chain_done <= 1'b0;
                end
                ST_FETCH: if (desc_valid) begin
                    st     <= ST_OFFER;
                    link_q <= desc.link;
                    end_q  <= desc.is_end;
                end
                ST_OFFER: if (seg_valid && seg_ready) st <= ST_AWAIT;
                ST_AWAIT: if (seg_done) begin
                    if (end_q) begin
                        st         <= ST_IDLE;
                        chain_done <= 1'b1;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R7: completion and activity are exclusive
    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        chain_done |-> !busy);

    // R7: no reads while idle
    p_no_read_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !rd_req_valid);

    // R6: a followed link is word aligned
    p_link_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_req_valid) && $past(st == ST_AWAIT) |-> rd_req_addr[FLAG_BITS-1:0] == '0);

    // R3: segment offer and descriptor reads never overlap
    p_offer_excl_r3: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> !rd_req_valid);

    // R9: a pointer write cannot end an active walk
    p_ignore_wr_r9: assert property (@(posedge clk) disable iff (rst)
        busy && ptr_wr && !seg_done |=> busy);

endmodule

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int MAX_DESC   = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        ptr_wr;
    logic [31:0] ptr_value;
    logic        rd_req_valid;
    logic        rd_req_ready;
    logic [31:0] rd_req_addr;
    logic        rd_rsp_valid;
    logic [31:0] rd_rsp_data;
    logic        seg_valid;
    logic        seg_ready;
    logic [31:0] seg_addr;
    logic [31:0] seg_len;
    logic        seg_to_host;
    logic        seg_done;
    logic        busy;
    logic        chain_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sg_chain_walker dut_i (
        .clk          (clk),
        .rst          (rst),
        .ptr_wr       (ptr_wr),
        .ptr_value    (ptr_value),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .seg_valid    (seg_valid),
        .seg_ready    (seg_ready),
        .seg_addr     (seg_addr),
        .seg_len      (seg_len),
        .seg_to_host  (seg_to_host),
        .seg_done     (seg_done),
        .busy         (busy),
        .chain_done   (chain_done)
    );

    logic [31:0] c_loc  [MAX_DESC];
    logic [31:0] c_addr [MAX_DESC];
    logic [31:0] c_len  [MAX_DESC];
    logic        c_dir  [MAX_DESC];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] link_word(input int k, input int n);
        logic [31:0] nxt;
        nxt = (k == n - 1) ? (($urandom() & 32'hFFFF_FFF0)) : c_loc[k+1];
        return {nxt[31:2], c_dir[k], (k == n - 1)};
    endfunction

    task automatic wait_high(ref logic sig);
        int guard = 0;
        while (!sig && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic serve_word(input logic [31:0] exp_addr, input logic [31:0] data, input string req);
        int stall;
        int lat;
        wait_high(rd_req_valid);
        check(rd_req_valid && rd_req_addr == exp_addr, req, rd_req_addr, exp_addr);
        stall = $urandom_range(0, 2);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(rd_req_valid && rd_req_addr == exp_addr, "R8 req hold", rd_req_addr, exp_addr);
        end
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        lat = $urandom_range(0, 3);
        for (int i = 0; i < lat; i++) begin
            check(!rd_req_valid, "R3 single outstanding", {31'b0, rd_req_valid}, 32'd0);
            @(negedge clk);
        end
        check(!rd_req_valid, "R3 single outstanding", {31'b0, rd_req_valid}, 32'd0);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = data;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = $urandom();
    endtask

    task automatic run_chain(input int n, input bit inject);
        logic [31:0] w2;
        int stall;
        int gap;
        ptr_wr    = 1'b1;
        ptr_value = c_loc[0];
        @(negedge clk);
        ptr_wr = 1'b0;
        check(busy == 1'b1, "R2 busy after start", {31'b0, busy}, 32'd1);
        check(chain_done == 1'b0, "R10 done cleared by start", {31'b0, chain_done}, 32'd0);
        for (int k = 0; k < n; k++) begin
            w2 = link_word(k, n);
            if (inject && k > 0) begin
                ptr_wr    = 1'b1;
                ptr_value = 32'hDEAD_0000 + 32'(k * 16);
                @(negedge clk);
                ptr_wr = 1'b0;
            end
            serve_word(c_loc[k], c_addr[k], (k == 0) ? "R2 first read addr" : (inject ? "R9 R6 link addr" : "R6 link addr"));
            serve_word(c_loc[k] + 32'd4, c_len[k], "R3 word1 addr");
            serve_word(c_loc[k] + 32'd8, w2, "R3 word2 addr");
            wait_high(seg_valid);
            check(seg_valid && seg_addr == c_addr[k], "R4 seg addr", seg_addr, c_addr[k]);
            check(seg_len == c_len[k], "R4 seg len", seg_len, c_len[k]);
            check(seg_to_host == c_dir[k], "R5 direction", {31'b0, seg_to_host}, {31'b0, c_dir[k]});
            stall = $urandom_range(0, 3);
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                check(seg_valid && seg_addr == c_addr[k] && seg_len == c_len[k], "R8 seg hold", seg_addr, c_addr[k]);
            end
            seg_ready = 1'b1;
            @(negedge clk);
            seg_ready = 1'b0;
            check(!seg_valid, "R8 seg taken", {31'b0, seg_valid}, 32'd0);
            gap = $urandom_range(0, 4);
            for (int i = 0; i < gap; i++) begin
                @(negedge clk);
                check(!rd_req_valid && busy, "R6 waits for done", {30'b0, busy, rd_req_valid}, 32'd2);
            end
            seg_done = 1'b1;
            @(negedge clk);
            seg_done = 1'b0;
        end
        check(chain_done == 1'b1 && busy == 1'b0, "R7 chain done", {30'b0, chain_done, busy}, 32'd2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!rd_req_valid && chain_done, "R10 R7 idle hold", {30'b0, chain_done, rd_req_valid}, 32'd2);
        end
    endtask

    task automatic random_chain(input int n, input bit inject);
        for (int k = 0; k < n; k++) begin
            c_loc[k]  = ($urandom() & 32'hFFFF_FFF0) | 32'(k * 4) & 32'hC;
            c_loc[k]  = c_loc[k] & 32'hFFFF_FFFC;
            c_addr[k] = $urandom();
            c_len[k]  = $urandom_range(1, 65536);
            c_dir[k]  = 1'($urandom_range(0, 1));
        end
        run_chain(n, inject);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst          = 1'b1;
        ptr_wr       = 1'b0;
        ptr_value    = '0;
        rd_req_ready = 1'b0;
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = '0;
        seg_ready    = 1'b0;
        seg_done     = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !chain_done && !rd_req_valid && !seg_valid, "R1 reset state",
              {28'b0, busy, chain_done, rd_req_valid, seg_valid}, 32'd0);

        // directed: single descriptor, board to host
        c_loc[0] = 32'h0000_1000; c_addr[0] = 32'hA000_0000; c_len[0] = 32'd64; c_dir[0] = 1'b1;
        run_chain(1, 1'b0);

        // directed: three descriptors, mixed directions, pointer writes mid-walk
        c_loc[0] = 32'h0000_2000; c_addr[0] = 32'h1111_0000; c_len[0] = 32'd4;    c_dir[0] = 1'b0;
        c_loc[1] = 32'hFFFF_FFF0; c_addr[1] = 32'h2222_0004; c_len[1] = 32'd1;    c_dir[1] = 1'b1;
        c_loc[2] = 32'h0000_0010; c_addr[2] = 32'h3333_0008; c_len[2] = 32'hFFFF; c_dir[2] = 1'b1;
        run_chain(3, 1'b1);

        for (int t = 0; t < 20; t++) begin
            random_chain($urandom_range(1, MAX_DESC), (t % 3) == 0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule